// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

This block is an up-counting timer whose 16-bit count is held as a low byte and a high byte. A pair of reload bytes supplies the value the count takes when it wraps. In the default mode the two bytes form one 16-bit counter. When it passes 0xFFFF it reloads from both reload bytes and raises the high overflow flag.

With the split select set, the bytes become two independent 8-bit auto-reload counters. Both counters advance on the same tick, and each reloads from its own reload byte. Three tick sources can be chosen: every system clock cycle, one cycle in twelve, or one tick per eight rising edges of an external clock. The external clock is synchronized into the system clock domain before use.

Software controls the block through plain register-style inputs. These are a run enable, the split select, a source select, a timer interrupt enable and a low-byte interrupt enable. Software writes the count and reload bytes through byte strobes and clears the sticky overflow flags with clear strobes. One combined interrupt request is formed from the flags.

Top module: `split_reload_timer`

## Requirements
- R1: After reset the count, both reload bytes, both overflow flags and the interrupt request are all 0.
- R2: While run_en is 0 the count holds its value. While run_en is 1 the count advances once per selected tick.
- R3: With split_mode 0, each tick adds one to the 16-bit count. A tick at 0xFFFF instead loads {rld_q[15:8], rld_q[7:0]} and sets flag_hi.
- R4: With split_mode 0, a tick while the low byte is 0xFF sets flag_lo only when lo_irq_en is 1. Otherwise flag_lo is untouched.
- R5: With split_mode 1, the low byte (cnt_q[7:0]) and the high byte (cnt_q[15:8]) each increment on every tick. A byte at 0xFF loads its own reload byte instead. A high-byte wrap sets flag_hi and a low-byte wrap sets flag_lo, whatever the value of lo_irq_en.
- R6: src_sel selects the tick source: 2'b00 gives every cycle, 2'b01 gives one cycle in every 12 from a free-running divider, and 2'b1x gives one tick per 8 rising edges of ext_clk. Any 12 consecutive cycles on source 01 hold exactly one tick. An ext_clk edge reaches the count on the third clock edge after it.
- R7: An overflow flag stays set until its clear strobe is high at a clock edge. A set event in the same cycle as a clear leaves the flag set.
- R8: irq equals irq_en AND (flag_hi OR (lo_irq_en AND flag_lo)).
- R9: A count byte write (cnt_wr_lo, cnt_wr_hi with cnt_wdata) replaces that byte at the next edge. In that cycle it suppresses the tick, so there is no increment and no overflow event. Reload byte writes appear on rld_q at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Asynchronous external clock |
| run_en | input | 1 | Counting enable |
| split_mode | input | 1 | 1 = two 8-bit timers, 0 = one 16-bit timer |
| src_sel | input | 2 | Tick source: 00 clock, 01 clock/12, 1x external/8 |
| irq_en | input | 1 | Timer interrupt enable |
| lo_irq_en | input | 1 | Low-byte overflow interrupt enable |
| cnt_wr_lo | input | 1 | Write strobe, count low byte |
| cnt_wr_hi | input | 1 | Write strobe, count high byte |
| cnt_wdata | input | 16 | Count write data (bytes selected by strobes) |
| rld_wr_lo | input | 1 | Write strobe, reload low byte |
| rld_wr_hi | input | 1 | Write strobe, reload high byte |
| rld_wdata | input | 16 | Reload write data (bytes selected by strobes) |
| flag_clr_hi | input | 1 | Clear strobe, high overflow flag |
| flag_clr_lo | input | 1 | Clear strobe, low overflow flag |
| cnt_q | output | 16 | Current count {high, low} |
| rld_q | output | 16 | Reload value {high, low} |
| flag_hi | output | 1 | High overflow flag |
| flag_lo | output | 1 | Low overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
On the clock source, count, flags and reload bytes change at the first edge after the stimulus. The bench runs exactly N edges with run_en high and samples at the falling edge that follows, so the expected count is the start value advanced N times. irq is combinational from the flags and is read in the same half cycle. The divided sources have a phase the bench cannot see, so it runs windows of exactly 36 cycles for the /12 source. For the external source it applies 16 edges and then waits more than the three-edge synchronizer delay; the expected advance is then exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'b00,
    SRC_SLOW  = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_EXT_B = 2'b11
  } tick_src_e;

  // One byte step: wrap to the reload byte, else increment.
  function automatic logic [BYTE_W-1:0] byte_step(input logic [BYTE_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] rld);
    return (cur == {BYTE_W{1'b1}}) ? rld : cur + 1'b1;
  endfunction

  // Full-width step for the joined mode.
  function automatic logic [2*BYTE_W-1:0] word_step(input logic [2*BYTE_W-1:0] cur,
                                                    input logic [2*BYTE_W-1:0] rld);
    return (cur == {2*BYTE_W{1'b1}}) ? rld : cur + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic [1:0] src_sel,
  output logic       tick
);
  import tmr_pkg::*;
  localparam int SW = $clog2(DIV_SLOW);
  localparam int XW = $clog2(DIV_EXT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_rise;
  logic [SW-1:0]          slow_cnt;
  logic [XW-1:0]          ext_cnt;
  logic                   slow_tick, ext_tick;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_clk;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              slow_cnt <= '0;
    else if (slow_cnt == SW'(DIV_SLOW - 1))  slow_cnt <= '0;
    else                                     slow_cnt <= slow_cnt + 1'b1;

  assign slow_tick = (slow_cnt == SW'(DIV_SLOW - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ext_cnt <= '0;
    else if (ext_rise) ext_cnt <= (ext_cnt == XW'(DIV_EXT - 1)) ? '0 : ext_cnt + 1'b1;

  assign ext_tick = ext_rise & (ext_cnt == XW'(DIV_EXT - 1));

  always_comb begin
    unique case (tick_src_e'(src_sel))
      SRC_SYS:  tick = 1'b1;
      SRC_SLOW: tick = slow_tick;
      default:  tick = ext_tick;
    endcase
  end

  // R6: the synchronized edge is a single-cycle pulse
  a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
  // R6: the slow divider never runs past its terminal value
  a_r6_slow_range: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> (slow_cnt == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int BW = tmr_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          split,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata_lo,
  input  logic [BW-1:0] wdata_hi,
  input  logic [BW-1:0] rld_lo,
  input  logic [BW-1:0] rld_hi,
  output logic [BW-1:0] cnt_lo,
  output logic [BW-1:0] cnt_hi,
  output logic          ev_lo,
  output logic          ev_hi
);
  import tmr_pkg::*;
  localparam logic [BW-1:0] TOP = {BW{1'b1}};

  logic          tick_eff;
  logic [BW-1:0] nxt_lo, nxt_hi;

  assign tick_eff = tick & ~(wr_lo | wr_hi);
  assign ev_lo    = tick_eff & (cnt_lo == TOP);
  assign ev_hi    = tick_eff & (cnt_hi == TOP) & (split | (cnt_lo == TOP));

  always_comb begin
    if (split) begin
      nxt_lo = byte_step(cnt_lo, rld_lo);
      nxt_hi = byte_step(cnt_hi, rld_hi);
    end else begin
      {nxt_hi, nxt_lo} = word_step({cnt_hi, cnt_lo}, {rld_hi, rld_lo});
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_lo <= wdata_lo;
      if (wr_hi) cnt_hi <= wdata_hi;
    end else if (tick_eff) begin
      cnt_lo <= nxt_lo;
      cnt_hi <= nxt_hi;
    end

  // R2: no tick and no write leaves the count unchanged
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  // R3: joined wrap loads the reload pair
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && !split && cnt_lo == TOP && cnt_hi == TOP)
      |=> ({cnt_hi, cnt_lo} == $past({rld_hi, rld_lo})));
  // R5: split low byte reloads from its own byte
  a_r5_split_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && split && cnt_lo == TOP) |=> (cnt_lo == $past(rld_lo)));
  // R9: a count write suppresses overflow events
  a_r9_write_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |-> (!ev_lo && !ev_hi));
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;

  // R7: set has priority over clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R7: flag is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer #(
  parameter int BW          = tmr_pkg::BYTE_W,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk,
  input  logic            run_en,
  input  logic            split_mode,
  input  logic [1:0]      src_sel,
  input  logic            irq_en,
  input  logic            lo_irq_en,
  input  logic            cnt_wr_lo,
  input  logic            cnt_wr_hi,
  input  logic [2*BW-1:0] cnt_wdata,
  input  logic            rld_wr_lo,
  input  logic            rld_wr_hi,
  input  logic [2*BW-1:0] rld_wdata,
  input  logic            flag_clr_hi,
  input  logic            flag_clr_lo,
  output logic [2*BW-1:0] cnt_q,
  output logic [2*BW-1:0] rld_q,
  output logic            flag_hi,
  output logic            flag_lo,
  output logic            irq
);
  logic          src_tick, run_tick;
  logic [BW-1:0] rld_lo_q, rld_hi_q, cnt_lo, cnt_hi;
  logic          ev_lo, ev_hi;
  logic [1:0]    flag_set, flag_clr, flag_q;

  tmr_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_EXT(DIV_EXT), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .src_sel(src_sel), .tick(src_tick));

  assign run_tick = src_tick & run_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else begin
      if (rld_wr_lo) rld_lo_q <= rld_wdata[BW-1:0];
      if (rld_wr_hi) rld_hi_q <= rld_wdata[2*BW-1:BW];
    end

  tmr_count_core #(.BW(BW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(run_tick), .split(split_mode),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
    .wdata_lo(cnt_wdata[BW-1:0]), .wdata_hi(cnt_wdata[2*BW-1:BW]),
    .rld_lo(rld_lo_q), .rld_hi(rld_hi_q),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ev_lo(ev_lo), .ev_hi(ev_hi));

  // index 0: low flag, index 1: high flag
  assign flag_set[0] = ev_lo & (split_mode | lo_irq_en);
  assign flag_set[1] = ev_hi;
  assign flag_clr    = {flag_clr_hi, flag_clr_lo};

  genvar f;
  generate
    for (f = 0; f < 2; f++) begin : g_flag
      tmr_flag_bit u_flag (.clk(clk), .rst_n(rst_n), .set(flag_set[f]),
                           .clr(flag_clr[f]), .q(flag_q[f]));
    end
  endgenerate

  assign cnt_q   = {cnt_hi, cnt_lo};
  assign rld_q   = {rld_hi_q, rld_lo_q};
  assign flag_lo = flag_q[0];
  assign flag_hi = flag_q[1];
  assign irq     = irq_en & (flag_hi | (lo_irq_en & flag_lo));

  // R8: interrupt only with the enable and a qualifying flag
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (flag_hi || flag_lo)));
  // R4: in joined mode a masked low wrap never sets the low flag
  a_r4_lo_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_lo && !split_mode && !lo_irq_en) |=> !flag_lo);
  // R2: counting never happens with run disabled
  a_r2_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt_q));
endmodule

// File: tb/split_reload_timer_tb.sv
module split_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        run_en = 1'b0, split_mode = 1'b0, irq_en = 1'b0, lo_irq_en = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        cnt_wr_lo = 1'b0, cnt_wr_hi = 1'b0, rld_wr_lo = 1'b0, rld_wr_hi = 1'b0;
  logic [15:0] cnt_wdata = '0, rld_wdata = '0;
  logic        flag_clr_hi = 1'b0, flag_clr_lo = 1'b0;
  logic [15:0] cnt_q, rld_q;
  logic        flag_hi, flag_lo, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  split_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .run_en(run_en),
    .split_mode(split_mode), .src_sel(src_sel), .irq_en(irq_en), .lo_irq_en(lo_irq_en),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .cnt_wdata(cnt_wdata),
    .rld_wr_lo(rld_wr_lo), .rld_wr_hi(rld_wr_hi), .rld_wdata(rld_wdata),
    .flag_clr_hi(flag_clr_hi), .flag_clr_lo(flag_clr_lo),
    .cnt_q(cnt_q), .rld_q(rld_q), .flag_hi(flag_hi), .flag_lo(flag_lo), .irq(irq));

  typedef struct packed {
    logic        split;
    logic        lie;
    logic [15:0] start;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_hi;
    logic        exp_lo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 16'h0000, 16'h1234, 8'd5, 16'h0005, 1'b0, 1'b0},  // R3 plain count
    '{1'b0, 1'b1, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 1'b1, 1'b1},  // R3 wrap + reload
    '{1'b0, 1'b1, 16'h00FE, 16'h0000, 8'd3, 16'h0101, 1'b0, 1'b1},  // R4 low wrap enabled
    '{1'b0, 1'b0, 16'h00FE, 16'h0000, 8'd3, 16'h0101, 1'b0, 1'b0},  // R4 low wrap masked
    '{1'b1, 1'b0, 16'h10FE, 16'h2080, 8'd3, 16'h1381, 1'b0, 1'b1},  // R5 low reload
    '{1'b1, 1'b1, 16'hFF05, 16'hF000, 8'd2, 16'hF107, 1'b1, 1'b0},  // R5 high reload
    '{1'b1, 1'b0, 16'hFFFF, 16'hAA55, 8'd1, 16'hAA55, 1'b1, 1'b1},  // R5 both wrap
    '{1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1, 1'b0}   // R3 reload to max
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Load count and reload with run stopped, clear both flags.
  task automatic preset(input logic [15:0] c, input logic [15:0] r);
    @(negedge clk);
    run_en = 1'b0;
    cnt_wdata = c; cnt_wr_lo = 1'b1; cnt_wr_hi = 1'b1;
    rld_wdata = r; rld_wr_lo = 1'b1; rld_wr_hi = 1'b1;
    flag_clr_hi = 1'b1; flag_clr_lo = 1'b1;
    @(negedge clk);
    cnt_wr_lo = 1'b0; cnt_wr_hi = 1'b0; rld_wr_lo = 1'b0; rld_wr_hi = 1'b0;
    flag_clr_hi = 1'b0; flag_clr_lo = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    if (n > 0) begin
      run_en = 1'b1;
      repeat (n) @(negedge clk);
      run_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_q, 0);
    chk("R1 rld", rld_q, 0);
    chk("R1 flags", {flag_hi, flag_lo}, 0);
    chk("R1 irq", irq, 0);

    // Vector table, system-clock source
    for (int i = 0; i < NV; i++) begin
      split_mode = VEC[i].split;
      lo_irq_en  = VEC[i].lie;
      src_sel    = 2'b00;
      preset(VEC[i].start, VEC[i].rld);
      run_cycles(int'(VEC[i].n));
      chk(VEC[i].split ? "R5 cnt" : "R3 cnt", cnt_q, VEC[i].exp_cnt);
      chk("R3/R5 flag_hi", flag_hi, VEC[i].exp_hi);
      chk("R4/R5 flag_lo", flag_lo, VEC[i].exp_lo);
    end

    // R9 reload readback
    chk("R9 rld readback", rld_q, 16'hFFFF);

    // R2 hold while stopped
    split_mode = 1'b0; lo_irq_en = 1'b0;
    preset(16'h0042, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R2 hold", cnt_q, 16'h0042);

    // R9 write wins over tick, no increment that cycle
    run_en = 1'b1; cnt_wdata = 16'h0040; cnt_wr_lo = 1'b1;
    @(negedge clk);
    run_en = 1'b0; cnt_wr_lo = 1'b0;
    chk("R9 write no tick", cnt_q, 16'h0040);
    // R9 write at 0xFF low byte with lo irq enabled: no flag event
    lo_irq_en = 1'b1;
    preset(16'h00FF, 16'h0000);
    run_en = 1'b1; cnt_wdata = 16'h0700; cnt_wr_hi = 1'b1;
    @(negedge clk);
    run_en = 1'b0; cnt_wr_hi = 1'b0;
    chk("R9 write hi only", cnt_q, 16'h07FF);
    chk("R9 no event", flag_lo, 1'b0);

    // R7 sticky and set-wins
    preset(16'hFFFF, 16'h0100);
    run_cycles(1);
    chk("R7 set", flag_hi, 1'b1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", flag_hi, 1'b1);
    cnt_wdata = 16'hFFFF; cnt_wr_lo = 1'b1; cnt_wr_hi = 1'b1;
    @(negedge clk);
    cnt_wr_lo = 1'b0; cnt_wr_hi = 1'b0;
    run_en = 1'b1; flag_clr_hi = 1'b1;
    @(negedge clk);
    run_en = 1'b0; flag_clr_hi = 1'b0;
    chk("R7 set beats clear", flag_hi, 1'b1);
    flag_clr_hi = 1'b1;
    @(negedge clk);
    flag_clr_hi = 1'b0;
    chk("R7 clear", flag_hi, 1'b0);

    // R8 interrupt combine: flag_lo set, flag_hi clear
    split_mode = 1'b1; lo_irq_en = 1'b1;
    preset(16'h00FF, 16'h0000);
    run_cycles(1);
    irq_en = 1'b0;
    #1 chk("R8 irq disabled", irq, 1'b0);
    irq_en = 1'b1;
    #1 chk("R8 irq lo", irq, 1'b1);
    lo_irq_en = 1'b0;
    #1 chk("R8 lo masked", irq, 1'b0);
    irq_en = 1'b0;
    split_mode = 1'b0;

    // R6 clock/12 source: 36 cycles hold exactly 3 ticks
    src_sel = 2'b01;
    preset(16'h0100, 16'h0000);
    run_cycles(36);
    chk("R6 div12", cnt_q, 16'h0103);

    // R6 external/8 source: 16 edges give 2 ticks
    src_sel = 2'b10;
    preset(16'h0200, 16'h0000);
    run_en = 1'b1;
    for (int e = 0; e < 16; e++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    run_en = 1'b0;
    chk("R6 ext8", cnt_q, 16'h0202);
    src_sel = 2'b00;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule